// File: doc/BRIEF.md
# Sectored Write-Back Cache Line Store

This block is a direct-mapped data cache that sits between a CPU word port and a next-level memory port. Each 64-byte line is split into sixteen 4-byte sectors. Every sector keeps its own valid and dirty flag, and the line keeps one valid flag and a tag. Because of this per-sector state the memory port moves one sector at a time and never a whole line. A read that misses fetches only the sector it needs. A full-word write to a sector needs no fetch at all.

The cache uses a write-back, write-allocate policy. Writes stay in the cache until the line is displaced. When a request carries a tag that differs from the tag stored in its line, the controller sends every dirty sector of the old line to memory, lowest sector first. It then clears all sector state and installs the new tag.

A CPU request is presented with `cpu_valid` and held stable until `cpu_ready` is high. `cpu_ready` rises in the cycle the access completes, and read data is valid in that same cycle. Memory requests are held until a one-cycle `mem_ack`.

Top module: `sector_cache`

## Requirements
- R1: After reset, every line and every sector is invalid and clean, so the first read to any address fetches that sector from memory.
- R2: A read miss issues exactly one memory read, for the addressed sector only, and returns the memory word.
- R3: A read to a valid sector of a line whose stored tag matches completes with no memory traffic and returns the cached word.
- R4: A write with all four byte enables set, to an invalid sector of a line whose tag matches, completes without any memory access and marks the sector valid and dirty.
- R5: On a tag mismatch, after any write-backs the line takes the new tag with all sectors invalid and clean. A full-word write miss to a line with no dirty sectors causes no memory access.
- R6: A write with some byte enables clear, to an invalid sector, first reads that one sector from memory and then merges the enabled bytes into it.
- R7: A write hit updates only the cache and marks the sector dirty; no memory write occurs until eviction.
- R8: Eviction writes back exactly the dirty sectors of the old line, one memory write per sector, in ascending sector order, at the old tag's address and with the cached data.
- R9: After a line is replaced, no sector of the old line is returned for the new tag. A later access to the old address fetches the value that was written back.
- R10: While a fill or write-back is pending, `cpu_ready` stays low, and each memory request holds its address, direction and data until `mem_ack`.
- R11: Evicting a line with no dirty sectors issues no memory write.
- R12: Address fields are byte-in-sector [1:0] (must be zero), sector [5:2], index [IDX_W+5:6] and tag above. Memory addresses are sector aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | CPU request present; held until accepted |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid when cpu_ready is high on a read |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_write | output | 1 | 1 = sector write-back, 0 = sector fill |
| mem_addr | output | ADDR_W | Sector-aligned memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | One-cycle completion of the memory request |
| mem_rdata | input | 32 | Fill data, valid with mem_ack |

## Verification
The bench counts memory reads and writes around every access and logs the order and payload of write-backs. Each corner case is checked this way:
- A cache that fetched whole lines would show sixteen reads where one is expected.
- A design that fetched before a full-word write would show an unexpected read.
- One that wrote through would show writes on hits.
- One that forgot to merge a partial write would return the raw memory word.
- An eviction that walks sectors out of order, or writes clean sectors, fails the logged order and count.
- Reading the new tag's sectors after a replacement catches stale sector-valid bits left from the old line.
- Reading an evicted address back catches write-backs sent to the wrong address.

// File: rtl/sc_pkg.sv
// Package: shared controller state type for the sectored cache.
package sc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } sc_state_e;
endpackage

// File: rtl/sc_first_set.sv
// sc_first_set: returns the position of the lowest set bit of a vector.
// Assumes N is a power of two; "any" is low when the vector is zero.
module sc_first_set #(
    parameter int N = 16
) (
    input  logic [N-1:0]         vec,
    output logic [$clog2(N)-1:0] pos,
    output logic                 any
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        pos = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                pos = i[$clog2(N)-1:0];
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sc_tag_store.sv
// sc_tag_store: per-line tag, line valid and per-sector valid/dirty flags.
// Assumes at most one update per cycle, all aimed at line "idx".
module sc_tag_store #(
    parameter int IDX_W = 2,
    parameter int SEC_W = 4,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic             line_v,
    output logic [TAG_W-1:0] line_tag,
    output logic [(1<<SEC_W)-1:0] sec_v,
    output logic [(1<<SEC_W)-1:0] sec_d,
    input  logic             install,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             set_sec,
    input  logic             set_dirty,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic             clr_dirty,
    input  logic [SEC_W-1:0] clr_sec
);
    localparam int LINES = 1 << IDX_W;
    localparam int NSEC  = 1 << SEC_W;

    logic [LINES-1:0] lv_q;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [NSEC-1:0]  sv_q  [LINES];
    logic [NSEC-1:0]  sd_q  [LINES];

    // Present the state of the addressed line.
    always_comb begin
        line_v   = lv_q[idx];
        line_tag = tag_q[idx];
        sec_v    = sv_q[idx];
        sec_d    = sd_q[idx];
    end

    // Apply install, sector-set and dirty-clear updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lv_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                sv_q[i]  <= '0;
                sd_q[i]  <= '0;
            end
        end else if (install) begin
            lv_q[idx]  <= 1'b1;
            tag_q[idx] <= new_tag;
            sv_q[idx]  <= '0;
            sd_q[idx]  <= '0;
        end else if (set_sec) begin
            sv_q[idx][upd_sec] <= 1'b1;
            if (set_dirty) sd_q[idx][upd_sec] <= 1'b1;
        end else if (clr_dirty) begin
            sd_q[idx][clr_sec] <= 1'b0;
        end
    end

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_d & ~sec_v) == '0); // R7
    AST_INSTALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        install |=> (line_v && sec_v == '0 && sec_d == '0)); // R5
endmodule

// File: rtl/sc_data_store.sv
// sc_data_store: word array, one word per sector, with byte-enabled writes.
// Two read ports: one for the CPU, one for the write-back path.
module sc_data_store #(
    parameter int IDX_W = 2,
    parameter int SEC_W = 4
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    input  logic [SEC_W-1:0] cpu_sec,
    output logic [31:0]      cpu_word,
    input  logic [SEC_W-1:0] wb_sec,
    output logic [31:0]      wb_word,
    input  logic             we,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata
);
    localparam int WORDS = 1 << (IDX_W + SEC_W);

    logic [31:0] mem_q [WORDS];

    // Combinational reads of the CPU sector and the write-back sector.
    always_comb begin
        cpu_word = mem_q[{idx, cpu_sec}];
        wb_word  = mem_q[{idx, wb_sec}];
    end

    // Byte-enabled write into the CPU sector.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) mem_q[{idx, cpu_sec}][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/sc_ctrl.sv
// sc_ctrl: hit check and miss sequencing (write-back of dirty sectors,
// install, single-sector fill). Assumes the CPU request is held while stalled.
module sc_ctrl
    import sc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2,
    parameter int SEC_W  = 4,
    parameter int TAG_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [3:0]        cpu_be,
    input  logic [TAG_W-1:0]  a_tag,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [SEC_W-1:0]  a_sec,
    output logic              cpu_ready,
    input  logic              line_v,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [(1<<SEC_W)-1:0] sec_v,
    input  logic [(1<<SEC_W)-1:0] sec_d,
    output logic              install,
    output logic              set_sec,
    output logic              set_dirty,
    output logic              clr_dirty,
    output logic [SEC_W-1:0]  wb_sec,
    output logic              ds_we,
    output logic              ds_from_mem,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack
);
    sc_state_e  state_q, state_d;
    logic       tag_eq, hit, any_dirty;

    sc_first_set #(.N(1 << SEC_W)) u_pick (
        .vec (sec_d),
        .pos (wb_sec),
        .any (any_dirty)
    );

    // Hit: tag matches and sector valid, or a full-word write claims it.
    always_comb begin
        tag_eq = line_v && (line_tag == a_tag);
        hit    = tag_eq && (sec_v[a_sec] || (cpu_write && (&cpu_be)));
    end

    // Next state, store updates and memory request.
    always_comb begin
        state_d     = state_q;
        cpu_ready   = 1'b0;
        install     = 1'b0;
        set_sec     = 1'b0;
        set_dirty   = 1'b0;
        clr_dirty   = 1'b0;
        ds_we       = 1'b0;
        ds_from_mem = 1'b0;
        mem_req     = 1'b0;
        mem_write   = 1'b0;
        mem_addr    = {a_tag, a_idx, a_sec, 2'b00};
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_valid) begin
                    if (hit) begin
                        cpu_ready = 1'b1;
                        if (cpu_write) begin
                            ds_we     = 1'b1;
                            set_sec   = 1'b1;
                            set_dirty = 1'b1;
                        end
                    end else if (!tag_eq) begin
                        state_d = ST_EVICT;
                    end else begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                if (any_dirty) begin
                    mem_req   = 1'b1;
                    mem_write = 1'b1;
                    mem_addr  = {line_tag, a_idx, wb_sec, 2'b00};
                    clr_dirty = mem_ack;
                end else begin
                    install = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    ds_we       = 1'b1;
                    ds_from_mem = 1'b1;
                    set_sec     = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    AST_STALL_ON_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write))); // R10
    AST_WB_DIRTY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_write) |-> sec_d[mem_addr[SEC_W+1:2]]); // R8
    AST_FILL_MISSING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_write) |-> !sec_v[mem_addr[SEC_W+1:2]]); // R2
    AST_WB_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_write && mem_ack) |=>
        (!(mem_req && mem_write) || (mem_addr[SEC_W+1:2] > $past(mem_addr[SEC_W+1:2])))); // R8
endmodule

// File: rtl/sector_cache.sv
// sector_cache: direct-mapped write-back, write-allocate cache with 64-byte
// lines of sixteen 4-byte sectors, each with its own valid and dirty flag.
// Assumes word-aligned CPU accesses held stable until cpu_ready.
module sector_cache #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [3:0]        cpu_be,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam int SEC_W = 4;
    localparam int NSEC  = 1 << SEC_W;
    localparam int TAG_W = ADDR_W - IDX_W - SEC_W - 2;

    logic [TAG_W-1:0] a_tag, line_tag;
    logic [IDX_W-1:0] a_idx;
    logic [SEC_W-1:0] a_sec, wb_sec;
    logic [NSEC-1:0]  sec_v, sec_d;
    logic line_v, install, set_sec, set_dirty, clr_dirty, ds_we, ds_from_mem;
    logic [3:0]  ds_be;
    logic [31:0] ds_wdata;

    // Split the CPU address into tag, index and sector fields.
    always_comb begin
        a_sec = cpu_addr[SEC_W+1:2];
        a_idx = cpu_addr[IDX_W+SEC_W+1:SEC_W+2];
        a_tag = cpu_addr[ADDR_W-1:IDX_W+SEC_W+2];
    end

    // Fills write a whole word from memory; CPU writes use byte enables.
    always_comb begin
        ds_be    = ds_from_mem ? 4'hF : cpu_be;
        ds_wdata = ds_from_mem ? mem_rdata : cpu_wdata;
    end

    sc_tag_store #(.IDX_W(IDX_W), .SEC_W(SEC_W), .TAG_W(TAG_W)) u_tags (
        .clk (clk), .rst_n (rst_n), .idx (a_idx),
        .line_v (line_v), .line_tag (line_tag), .sec_v (sec_v), .sec_d (sec_d),
        .install (install), .new_tag (a_tag),
        .set_sec (set_sec), .set_dirty (set_dirty), .upd_sec (a_sec),
        .clr_dirty (clr_dirty), .clr_sec (wb_sec)
    );

    sc_data_store #(.IDX_W(IDX_W), .SEC_W(SEC_W)) u_data (
        .clk (clk), .idx (a_idx),
        .cpu_sec (a_sec), .cpu_word (cpu_rdata),
        .wb_sec (wb_sec), .wb_word (mem_wdata),
        .we (ds_we), .be (ds_be), .wdata (ds_wdata)
    );

    sc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEC_W(SEC_W), .TAG_W(TAG_W)) u_ctrl (
        .clk (clk), .rst_n (rst_n),
        .cpu_valid (cpu_valid), .cpu_write (cpu_write), .cpu_be (cpu_be),
        .a_tag (a_tag), .a_idx (a_idx), .a_sec (a_sec), .cpu_ready (cpu_ready),
        .line_v (line_v), .line_tag (line_tag), .sec_v (sec_v), .sec_d (sec_d),
        .install (install), .set_sec (set_sec), .set_dirty (set_dirty),
        .clr_dirty (clr_dirty), .wb_sec (wb_sec),
        .ds_we (ds_we), .ds_from_mem (ds_from_mem),
        .mem_req (mem_req), .mem_write (mem_write), .mem_addr (mem_addr),
        .mem_ack (mem_ack)
    );

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> (cpu_addr[1:0] == 2'b00)); // R12
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_write) |-> sec_v[a_sec]); // R3
endmodule

// File: tb/tb_sector_cache.sv
// tb_sector_cache: directed scenarios with a fixed-latency memory model.
module tb_sector_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ready, mem_req, mem_write;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int tests = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0, stall_cnt = 0, overlap = 0;
    logic [31:0] wlog_a [16];
    logic [31:0] wlog_d [16];
    logic [31:0] mem [1024];
    logic        busy = 1'b0;
    int          cnt = 0;
    logic [31:0] got;

    sector_cache dut (
        .clk (clk), .rst_n (rst_n),
        .cpu_valid (cpu_valid), .cpu_write (cpu_write), .cpu_addr (cpu_addr),
        .cpu_be (cpu_be), .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready), .cpu_rdata (cpu_rdata),
        .mem_req (mem_req), .mem_write (mem_write), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 ^ (i * 32'h0001_0203);
    endfunction

    // Memory model: fixed latency of 3 cycles, one-cycle ack.
    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (!busy && mem_req) begin
            busy <= 1'b1;
            cnt  <= 3;
        end else if (busy) begin
            if (cnt == 1) begin
                busy    <= 1'b0;
                mem_ack <= 1'b1;
                if (mem_write) begin
                    mem[mem_addr[11:2]] = mem_wdata;
                    if (wr_cnt < 16) begin
                        wlog_a[wr_cnt] = mem_addr;
                        wlog_d[wr_cnt] = mem_wdata;
                    end
                    wr_cnt++;
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                    rd_cnt++;
                end
            end
            cnt <= cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One CPU access; returns read data; counts stalled cycles.
    task automatic access(input bit wr, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_be = be; cpu_wdata = d;
        stall_cnt = 0;
        for (int k = 0; k < 2000; k++) begin
            #1;
            if (mem_req && cpu_ready) overlap++;
            if (cpu_ready) break;
            stall_cnt++;
            @(negedge clk);
        end
        rd = cpu_rdata;
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic t_reset_fill;
        int r0 = rd_cnt, w0 = wr_cnt;
        access(0, 32'h44, 4'h0, '0, got);
        chk(rd_cnt - r0 == 1, "R1 first read fetches", rd_cnt - r0, 1);
        chk(wr_cnt == w0, "R1 no write-back after reset", wr_cnt - w0, 0);
        chk(got == pat(17), "R2 fill data", got, pat(17));
        chk(stall_cnt > 0, "R10 stalled during fill", stall_cnt, 1);
        r0 = rd_cnt;
        access(0, 32'h48, 4'h0, '0, got);
        chk(rd_cnt - r0 == 1, "R2 only one sector fetched", rd_cnt - r0, 1);
        chk(got == pat(18), "R2 second sector data", got, pat(18));
    endtask

    task automatic t_read_hit;
        int r0 = rd_cnt;
        access(0, 32'h44, 4'h0, '0, got);
        chk(rd_cnt == r0 && stall_cnt == 0, "R3 hit without traffic", rd_cnt - r0, 0);
        chk(got == pat(17), "R3 hit data", got, pat(17));
    endtask

    task automatic t_full_write;
        int r0 = rd_cnt, w0 = wr_cnt;
        access(1, 32'h4C, 4'hF, 32'h1111_2222, got);
        chk(rd_cnt == r0 && wr_cnt == w0, "R4 full write no fetch", rd_cnt - r0, 0);
        access(0, 32'h4C, 4'h0, '0, got);
        chk(got == 32'h1111_2222 && rd_cnt == r0, "R4 written sector valid", got, 32'h1111_2222);
    endtask

    task automatic t_partial_write;
        int r0 = rd_cnt, w0 = wr_cnt;
        logic [31:0] e = {pat(20) >> 16, 16'hBBBB};
        access(1, 32'h50, 4'h3, 32'hAAAA_BBBB, got);
        chk(rd_cnt - r0 == 1 && wr_cnt == w0, "R6 partial write fetches one sector", rd_cnt - r0, 1);
        access(0, 32'h50, 4'h0, '0, got);
        chk(got == e, "R6 merged bytes", got, e);
    endtask

    task automatic t_write_hit;
        int r0 = rd_cnt, w0 = wr_cnt;
        access(1, 32'h44, 4'hF, 32'h3333_4444, got);
        chk(rd_cnt == r0 && wr_cnt == w0 && mem[17] == pat(17), "R7 write hit stays in cache", wr_cnt - w0, 0);
    endtask

    task automatic t_evict_dirty;
        int w0 = wr_cnt, r0 = rd_cnt;
        logic [31:0] e = {pat(20) >> 16, 16'hBBBB};
        access(0, 32'h144, 4'h0, '0, got);
        chk(wr_cnt - w0 == 3, "R8 three dirty sectors written", wr_cnt - w0, 3);
        chk(wlog_a[w0] == 32'h44 && wlog_d[w0] == 32'h3333_4444, "R8 first write-back", wlog_a[w0], 32'h44);
        chk(wlog_a[w0+1] == 32'h4C && wlog_d[w0+1] == 32'h1111_2222, "R8 second write-back", wlog_a[w0+1], 32'h4C);
        chk(wlog_a[w0+2] == 32'h50 && wlog_d[w0+2] == e, "R8 third write-back", wlog_d[w0+2], e);
        chk(rd_cnt - r0 == 1 && got == pat(81), "R5 new tag filled", got, pat(81));
        r0 = rd_cnt;
        access(0, 32'h148, 4'h0, '0, got);
        chk(rd_cnt - r0 == 1 && got == pat(82), "R9 no stale sector after replace", got, pat(82));
    endtask

    task automatic t_evict_clean;
        int w0 = wr_cnt;
        access(0, 32'h44, 4'h0, '0, got);
        chk(wr_cnt == w0, "R11 clean eviction writes nothing", wr_cnt - w0, 0);
        chk(got == 32'h3333_4444, "R9 old address reads written-back value", got, 32'h3333_4444);
    endtask

    task automatic t_write_miss;
        int w0 = wr_cnt, r0 = rd_cnt;
        access(1, 32'h2C0, 4'hF, 32'hCAFE_F00D, got);
        chk(wr_cnt == w0 && rd_cnt == r0, "R5 full write miss no traffic", rd_cnt - r0, 0);
        access(0, 32'h3C0, 4'h0, '0, got);
        chk(wr_cnt - w0 == 1 && wlog_a[w0] == 32'h2C0 && wlog_d[w0] == 32'hCAFE_F00D,
            "R12 write-back address fields", wlog_a[w0], 32'h2C0);
        chk(got == pat(240), "R12 index 3 fill data", got, pat(240));
        chk(overlap == 0, "R10 ready never with mem_req", overlap, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_fill();
        t_read_hit();
        t_full_write();
        t_partial_write();
        t_write_hit();
        t_evict_dirty();
        t_evict_clean();
        t_write_miss();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule